// File: doc/BRIEF.md
# Scaled-Index Load Unit

This unit executes one 64-bit indexed load at a time. The index register value is shifted left by one to four bit positions before it is added to the base. A decoder hands it the following, all in one accept cycle:

- the access size, which is byte, halfword, word or doubleword;
- a sign-extend flag, a byte-reverse flag and an update flag;
- the target and base register numbers;
- the base and index register values;
- a 2-bit shift field.

The unit works out the effective address and places one read request on a valid/ready memory port. It waits for the response and then shapes the returned data into the 64-bit result.

The result leaves through a single-cycle writeback port. Update forms also write the effective address back into the base register in that same cycle.

Before any memory traffic, the unit screens each accepted operation for illegal register combinations. A rejected operation produces a one-cycle illegal-form pulse and nothing else. Memory returns data big-endian and right-justified in the 64-bit response word. Any bits above the requested item are ignored. The sequencer walks idle, request, wait-for-data and writeback, and it takes a new operation only while idle.

Top module: `scaled_index_load`

## Requirements
- R1: The request address equals base + (index << (shift+1)) modulo 2^64, with shift a 2-bit field. Index bits shifted past bit 63 are lost.
- R2: Without update, a base register number of 0 gives a base of zero whatever the base value input. Otherwise the base is the base value input.
- R3: The size code is 0=byte, 1=halfword, 2=word, 3=doubleword. The request size output carries the byte count 1, 2, 4 or 8. Zero-extended loads put the item in the low 8, 16 or 32 result bits and clear the rest. Response bits above the item are ignored. The sign flag has no effect on byte loads.
- R4: With the sign flag set and byte-reverse clear, halfword and word loads copy the item's top bit into every higher result bit.
- R5: A doubleword load without byte-reverse returns the 64 response bits unchanged, whatever the sign flag.
- R6: With byte-reverse set, the bytes of the item are put in reverse order and the result is zero-extended. The sign flag is then ignored. A byte load is unchanged.
- R7: In the writeback cycle an update form also writes the address into the base register number. A non-update form never asserts the base write enable.
- R8: An operation is illegal when the update flag is set and either of these holds: the base register number is 0, or the access is a halfword with sign set, byte-reverse clear and base register number equal to target register number.
- R9: An illegal operation issues no request and no writeback. It raises the illegal-form output for exactly the one cycle after it is accepted, and the unit is idle again in that cycle.
- R10: A request stays valid with a steady address and size until it is taken. Each legal operation makes exactly one request, and a response is taken only while waiting for data.
- R11: The operation ready output is high only when idle. Writeback lasts one cycle, and the unit is ready again in the following cycle.
- R12: After reset the unit is idle and ready, with no request, no writeback and no illegal pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, accepts operation |
| op_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| op_sext | input | 1 | Sign-extend the loaded item |
| op_brev | input | 1 | Reverse the item's bytes |
| op_update | input | 1 | Write the address back to the base register |
| op_rt | input | 5 | Target register number |
| op_ra | input | 5 | Base register number |
| op_ra_val | input | 64 | Base register value |
| op_rb_val | input | 64 | Index register value |
| op_sh | input | 2 | Shift field, scale is shift+1 |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory takes request |
| mem_req_addr | output | 64 | Request byte address |
| mem_req_size | output | 4 | Request byte count |
| mem_rsp_valid | input | 1 | Response data valid |
| mem_rsp_ready | output | 1 | Unit takes response |
| mem_rsp_data | input | 64 | Right-justified big-endian data |
| wb_rt_en | output | 1 | Target register write enable |
| wb_rt_idx | output | 5 | Target register number |
| wb_rt_data | output | 64 | Formatted load result |
| wb_ra_en | output | 1 | Base register write enable |
| wb_ra_idx | output | 5 | Base register number |
| wb_ra_data | output | 64 | Address written to base register |
| illegal_form | output | 1 | One-cycle illegal-form pulse |

## Verification
The assertions run on every cycle and check the following:

- a pending request keeps its address and size until it is taken;
- every request size is a single power of two;
- writeback is a one-cycle pulse;
- a base write always comes with a target write and carries the address of the last request taken;
- an illegal pulse only follows an accept and never coincides with traffic.

Other behaviours can only be shown by the bench scenarios. These are the arithmetic of the address, including wrap-around and the zero base, the extension and byte-reverse results for every size, and which register combinations are rejected and which pass. They also include ignoring junk response bits and responses offered too early.

// File: rtl/sil_pkg.sv
package sil_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_WB   = 2'd3
  } state_e;
endpackage

// File: rtl/sil_addr_gen.sv
module sil_addr_gen #(
  parameter int DATA_W    = 64,
  parameter int REG_IDX_W = 5,
  parameter int SH_W      = 2
) (
  input  logic                 upd,
  input  logic [REG_IDX_W-1:0] ra_idx,
  input  logic [DATA_W-1:0]    ra_val,
  input  logic [DATA_W-1:0]    rb_val,
  input  logic [SH_W-1:0]      sh,
  output logic [DATA_W-1:0]    ea
);
  localparam int AMT_W = SH_W + 1;

  logic [DATA_W-1:0] base;
  logic [AMT_W-1:0]  amt;

  always_comb begin
    base = (!upd && ra_idx == '0) ? '0 : ra_val;
    amt  = {1'b0, sh} + AMT_W'(1);
    ea   = base + (rb_val << amt);
  end
endmodule

// File: rtl/sil_data_fmt.sv
module sil_data_fmt import sil_pkg::*; #(
  parameter int DATA_W = 64
) (
  input  size_e             size,
  input  logic              sext,
  input  logic              brev,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] result
);
  localparam int NB = DATA_W / 8;

  logic [NB-1:0]     lane_on;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] item;
  logic [DATA_W-1:0] rev;
  logic              sign;
  logic              do_sext;
  int                nbytes;

  assign nbytes = 1 << size;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_on[g]      = (g < nbytes);
    assign mask[8*g +: 8]  = {8{lane_on[g]}};
  end

  always_comb begin
    item = raw & mask;
    rev  = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < nbytes) rev[8*i +: 8] = raw[8*(nbytes-1-i) +: 8];
    end
    sign    = raw[8*nbytes-1];
    do_sext = sext && !brev && (size == SZ_HALF || size == SZ_WORD);
    if (brev)                 result = rev;
    else if (do_sext && sign) result = item | ~mask;
    else                      result = item;
  end
endmodule

// File: rtl/sil_seq_ctrl.sv
module sil_seq_ctrl import sil_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic op_valid,
  input  logic op_bad,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic op_ready,
  output logic accept,
  output logic req_valid,
  output logic rsp_ready,
  output logic rsp_take,
  output logic wb_en,
  output logic illegal_pulse
);
  state_e state_q, state_d;
  logic   illegal_d;

  always_comb begin
    state_d   = state_q;
    op_ready  = (state_q == ST_IDLE);
    req_valid = (state_q == ST_REQ);
    rsp_ready = (state_q == ST_WAIT);
    wb_en     = (state_q == ST_WB);
    accept    = op_ready && op_valid;
    rsp_take  = rsp_ready && rsp_valid;
    illegal_d = accept && op_bad;
    unique case (state_q)
      ST_IDLE: if (accept && !op_bad) state_d = ST_REQ;
      ST_REQ:  if (req_ready)         state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid)         state_d = ST_WB;
      ST_WB:                          state_d = ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      illegal_pulse <= 1'b0;
    end else begin
      state_q       <= state_d;
      illegal_pulse <= illegal_d;
    end
  end
endmodule

// File: rtl/scaled_index_load.sv
module scaled_index_load import sil_pkg::*; #(
  parameter int DATA_W    = 64,
  parameter int REG_IDX_W = 5,
  parameter int SH_W      = 2,
  localparam int SIZE_W   = $clog2(DATA_W / 8) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  output logic                 op_ready,
  input  logic [1:0]           op_size,
  input  logic                 op_sext,
  input  logic                 op_brev,
  input  logic                 op_update,
  input  logic [REG_IDX_W-1:0] op_rt,
  input  logic [REG_IDX_W-1:0] op_ra,
  input  logic [DATA_W-1:0]    op_ra_val,
  input  logic [DATA_W-1:0]    op_rb_val,
  input  logic [SH_W-1:0]      op_sh,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [DATA_W-1:0]    mem_req_addr,
  output logic [SIZE_W-1:0]    mem_req_size,
  input  logic                 mem_rsp_valid,
  output logic                 mem_rsp_ready,
  input  logic [DATA_W-1:0]    mem_rsp_data,
  output logic                 wb_rt_en,
  output logic [REG_IDX_W-1:0] wb_rt_idx,
  output logic [DATA_W-1:0]    wb_rt_data,
  output logic                 wb_ra_en,
  output logic [REG_IDX_W-1:0] wb_ra_idx,
  output logic [DATA_W-1:0]    wb_ra_data,
  output logic                 illegal_form
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  size_e             op_sz;
  logic              op_bad;
  logic              accept, rsp_take, wb_en;
  logic [DATA_W-1:0] ea_d, fmt_d;

  size_e                sz_q;
  logic                 sext_q, brev_q, upd_q;
  logic [REG_IDX_W-1:0] rt_q, ra_q;
  logic [DATA_W-1:0]    ea_q, res_q;

  assign op_sz  = size_e'(op_size);
  assign op_bad = op_update &&
                  ((op_ra == '0) ||
                   (op_sz == SZ_HALF && op_sext && !op_brev && op_ra == op_rt));

  sil_addr_gen #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W), .SH_W(SH_W)) u_agen (
    .upd    (op_update),
    .ra_idx (op_ra),
    .ra_val (op_ra_val),
    .rb_val (op_rb_val),
    .sh     (op_sh),
    .ea     (ea_d)
  );

  sil_data_fmt #(.DATA_W(DATA_W)) u_fmt (
    .size   (sz_q),
    .sext   (sext_q),
    .brev   (brev_q),
    .raw    (mem_rsp_data),
    .result (fmt_d)
  );

  sil_seq_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .op_valid      (op_valid),
    .op_bad        (op_bad),
    .req_ready     (mem_req_ready),
    .rsp_valid     (mem_rsp_valid),
    .op_ready      (op_ready),
    .accept        (accept),
    .req_valid     (mem_req_valid),
    .rsp_ready     (mem_rsp_ready),
    .rsp_take      (rsp_take),
    .wb_en         (wb_en),
    .illegal_pulse (illegal_form)
  );

  always_ff @(posedge clk) begin
    if (accept) begin
      sz_q   <= op_sz;
      sext_q <= op_sext;
      brev_q <= op_brev;
      upd_q  <= op_update;
      rt_q   <= op_rt;
      ra_q   <= op_ra;
      ea_q   <= ea_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_take) res_q <= fmt_d;
  end

  assign mem_req_addr = ea_q;
  assign mem_req_size = SIZE_W'(1) << sz_q;
  assign wb_rt_en     = wb_en;
  assign wb_rt_idx    = rt_q;
  assign wb_rt_data   = res_q;
  assign wb_ra_en     = wb_en && upd_q;
  assign wb_ra_idx    = ra_q;
  assign wb_ra_data   = ea_q;
endmodule

// File: rtl/sil_checker.sv
module sil_checker #(
  parameter int DATA_W    = 64,
  parameter int REG_IDX_W = 5,
  parameter int SIZE_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 op_valid,
  input logic                 op_ready,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic [DATA_W-1:0]    mem_req_addr,
  input logic [SIZE_W-1:0]    mem_req_size,
  input logic                 wb_rt_en,
  input logic                 wb_ra_en,
  input logic [DATA_W-1:0]    wb_ra_data,
  input logic                 illegal_form
);
  logic [DATA_W-1:0] taken_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             taken_addr <= '0;
    else if (mem_req_valid && mem_req_ready) taken_addr <= mem_req_addr;
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size));

  assert_req_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> $countones(mem_req_size) == 1);

  assert_wb_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_rt_en |=> !wb_rt_en && op_ready);

  assert_ra_with_rt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ra_en |-> wb_rt_en && wb_ra_data == taken_addr);

  assert_illegal_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(illegal_form) |-> $past(op_valid && op_ready));

  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_form |-> !mem_req_valid && !wb_rt_en && !wb_ra_en && op_ready);

  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !mem_req_valid && !wb_rt_en);
endmodule

bind scaled_index_load sil_checker #(
  .DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W), .SIZE_W(SIZE_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_valid      (op_valid),
  .op_ready      (op_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_size  (mem_req_size),
  .wb_rt_en      (wb_rt_en),
  .wb_ra_en      (wb_ra_en),
  .wb_ra_data    (wb_ra_data),
  .illegal_form  (illegal_form)
);

// File: tb/scaled_index_load_test.sv
module scaled_index_load_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_sext, op_brev, op_update;
  logic        op_ready;
  logic [1:0]  op_size, op_sh;
  logic [4:0]  op_rt, op_ra;
  logic [63:0] op_ra_val, op_rb_val;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [63:0] mem_req_addr, mem_rsp_data;
  logic [3:0]  mem_req_size;
  logic        wb_rt_en, wb_ra_en, illegal_form;
  logic [4:0]  wb_rt_idx, wb_ra_idx;
  logic [63:0] wb_rt_data, wb_ra_data;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;

  always #5 clk = ~clk;

  scaled_index_load uut (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready), .op_size(op_size),
    .op_sext(op_sext), .op_brev(op_brev), .op_update(op_update),
    .op_rt(op_rt), .op_ra(op_ra), .op_ra_val(op_ra_val),
    .op_rb_val(op_rb_val), .op_sh(op_sh),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data),
    .wb_rt_en(wb_rt_en), .wb_rt_idx(wb_rt_idx), .wb_rt_data(wb_rt_data),
    .wb_ra_en(wb_ra_en), .wb_ra_idx(wb_ra_idx), .wb_ra_data(wb_ra_data),
    .illegal_form(illegal_form)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_addr(bit upd, logic [4:0] ra, logic [63:0] rav,
                                           logic [63:0] rbv, logic [1:0] sh);
    logic [63:0] b, idx;
    b   = (!upd && ra == 0) ? 64'd0 : rav;
    idx = rbv;
    for (int k = 0; k <= int'(sh); k++) idx = {idx[62:0], 1'b0};
    return b + idx;
  endfunction

  function automatic logic [63:0] ref_result(logic [1:0] sz, bit sx, bit br, logic [63:0] raw);
    int          nb;
    logic [63:0] r;
    nb = 1 << sz;
    r  = 64'd0;
    for (int i = 0; i < nb; i++) begin
      if (br) r[8*i +: 8] = raw[8*(nb-1-i) +: 8];
      else    r[8*i +: 8] = raw[8*i +: 8];
    end
    if (!br && sx && (nb == 2 || nb == 4) && raw[8*nb-1])
      for (int i = nb; i < 8; i++) r[8*i +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic run_op(input string tag, input logic [1:0] sz, input bit sx, input bit br,
                        input bit upd, input logic [4:0] rt, input logic [4:0] ra,
                        input logic [63:0] rav, input logic [63:0] rbv, input logic [1:0] sh,
                        input logic [63:0] raw, input int req_lat, input int rsp_lat);
    bit          bad;
    logic [63:0] ea, res;
    bad = upd && (ra == 0 || (sz == 2'd1 && sx && !br && ra == rt));
    ea  = ref_addr(upd, ra, rav, rbv, sh);
    res = ref_result(sz, sx, br, raw);
    @(negedge clk);
    chk({tag, " R11 ready in idle"}, 64'(op_ready), 64'd1);
    op_valid = 1; op_size = sz; op_sext = sx; op_brev = br; op_update = upd;
    op_rt = rt; op_ra = ra; op_ra_val = rav; op_rb_val = rbv; op_sh = sh;
    @(negedge clk);
    op_valid = 0;
    op_ra_val = ~rav; op_rb_val = ~rbv;
    if (bad) begin
      chk({tag, " R8 R9 illegal pulse"}, 64'(illegal_form), 64'd1);
      chk({tag, " R9 no request"}, 64'(mem_req_valid), 64'd0);
      chk({tag, " R9 no writeback"}, 64'({wb_rt_en, wb_ra_en}), 64'd0);
      @(negedge clk);
      chk({tag, " R9 pulse one cycle"}, 64'(illegal_form), 64'd0);
      chk({tag, " R9 still no request"}, 64'(mem_req_valid), 64'd0);
      chk({tag, " R9 idle again"}, 64'(op_ready), 64'd1);
    end else begin
      chk({tag, " R12 no illegal on legal op"}, 64'(illegal_form), 64'd0);
      for (int k = 0; k < req_lat; k++) begin
        chk({tag, " R10 request held"}, 64'(mem_req_valid), 64'd1);
        chk({tag, " R1 R2 address"}, mem_req_addr, ea);
        chk({tag, " R10 no response taken in request"}, 64'(mem_rsp_ready), 64'd0);
        mem_rsp_valid = 1; mem_rsp_data = 64'hDEAD_BEEF_DEAD_BEEF;
        @(negedge clk);
        mem_rsp_valid = 0;
      end
      chk({tag, " R10 request valid"}, 64'(mem_req_valid), 64'd1);
      chk({tag, " R1 R2 address"}, mem_req_addr, ea);
      chk({tag, " R3 size bytes"}, 64'(mem_req_size), 64'(1 << sz));
      chk({tag, " R11 busy not ready"}, 64'(op_ready), 64'd0);
      mem_req_ready = 1;
      @(negedge clk);
      mem_req_ready = 0;
      chk({tag, " R10 single request"}, 64'(mem_req_valid), 64'd0);
      for (int k = 0; k < rsp_lat; k++) begin
        chk({tag, " R10 waiting for data"}, 64'(mem_rsp_ready), 64'd1);
        chk({tag, " R11 no early writeback"}, 64'(wb_rt_en), 64'd0);
        @(negedge clk);
      end
      mem_rsp_valid = 1; mem_rsp_data = raw;
      @(negedge clk);
      mem_rsp_valid = 0; mem_rsp_data = ~raw;
      chk({tag, " R11 rt write"}, 64'(wb_rt_en), 64'd1);
      chk({tag, " R11 rt index"}, 64'(wb_rt_idx), 64'(rt));
      chk({tag, " R3 R4 R5 R6 result"}, wb_rt_data, res);
      chk({tag, " R7 ra write enable"}, 64'(wb_ra_en), 64'(upd));
      if (upd) begin
        chk({tag, " R7 ra index"}, 64'(wb_ra_idx), 64'(ra));
        chk({tag, " R7 ra data"}, wb_ra_data, ea);
      end
      @(negedge clk);
      chk({tag, " R11 writeback one cycle"}, 64'(wb_rt_en), 64'd0);
      chk({tag, " R11 ready after writeback"}, 64'(op_ready), 64'd1);
    end
  endtask

  initial begin
    rst_n = 0; op_valid = 0; op_size = 0; op_sext = 0; op_brev = 0; op_update = 0;
    op_rt = 0; op_ra = 0; op_ra_val = 0; op_rb_val = 0; op_sh = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R12 reset ready", 64'(op_ready), 64'd1);
    chk("R12 reset no request", 64'(mem_req_valid), 64'd0);
    chk("R12 reset no writeback", 64'({wb_rt_en, wb_ra_en}), 64'd0);
    chk("R12 reset no illegal", 64'(illegal_form), 64'd0);

    run_op("R2 byte zero base", 2'd0, 1, 0, 0, 5'd7, 5'd0, 64'h1234_0000, 64'h10, 2'd0,
           64'hAAAA_BBBB_CCCC_DD85, 0, 0);
    run_op("R3 half zero", 2'd1, 0, 0, 0, 5'd8, 5'd3, 64'h1000, 64'h4, 2'd1,
           64'hFFFF_FFFF_FFFF_9ABC, 1, 2);
    run_op("R4 half sign neg update", 2'd1, 1, 0, 1, 5'd5, 5'd4, 64'h2000, 64'h3, 2'd2,
           64'h0000_0000_1111_8001, 2, 1);
    run_op("R4 half sign pos", 2'd1, 1, 0, 0, 5'd9, 5'd2, 64'h0, 64'h1, 2'd3,
           64'hFFFF_FFFF_FFFF_7FFF, 0, 3);
    run_op("R3 word zero", 2'd2, 0, 0, 0, 5'd1, 5'd2, 64'h40, 64'h2, 2'd0,
           64'h5555_5555_F000_0001, 1, 0);
    run_op("R4 word sign update", 2'd2, 1, 0, 1, 5'd10, 5'd11, 64'h8000, 64'h10, 2'd1,
           64'h0000_0000_8765_4321, 0, 1);
    run_op("R5 dword sign ignored", 2'd3, 1, 0, 0, 5'd12, 5'd13, 64'h100, 64'h8, 2'd2,
           64'hF123_4567_89AB_CDEF, 3, 0);
    run_op("R6 half reverse", 2'd1, 1, 1, 0, 5'd14, 5'd15, 64'h0, 64'h0, 2'd0,
           64'h9999_9999_9999_80FE, 0, 0);
    run_op("R6 word reverse", 2'd2, 0, 1, 0, 5'd16, 5'd17, 64'h30, 64'h5, 2'd1,
           64'hEEEE_EEEE_1122_3344, 1, 1);
    run_op("R6 dword reverse update", 2'd3, 0, 1, 1, 5'd18, 5'd19, 64'hFF00, 64'h2, 2'd3,
           64'h0102_0304_0506_0708, 0, 2);
    run_op("R6 byte reverse", 2'd0, 0, 1, 0, 5'd20, 5'd21, 64'h7, 64'h1, 2'd0,
           64'h1234_5678_9ABC_DE5A, 0, 0);
    run_op("R1 wrap", 2'd3, 0, 0, 0, 5'd22, 5'd23, 64'hFFFF_FFFF_FFFF_FFF0,
           64'h8000_0000_0000_0009, 2'd0, 64'h0, 1, 1);
    run_op("R1 shift four", 2'd2, 0, 0, 1, 5'd24, 5'd25, 64'h1, 64'h1800_0000_0000_0003, 2'd3,
           64'h7, 0, 0);
    run_op("R8 update base zero", 2'd2, 0, 0, 1, 5'd3, 5'd0, 64'h5, 64'h5, 2'd0, 64'h0, 0, 0);
    run_op("R8 half sign ra eq rt", 2'd1, 1, 0, 1, 5'd6, 5'd6, 64'h5, 64'h5, 2'd0, 64'h0, 0, 0);
    run_op("R8 reversed ra eq rt legal", 2'd1, 1, 1, 1, 5'd6, 5'd6, 64'h50, 64'h2, 2'd0,
           64'h0000_0000_0000_ABCD, 0, 0);
    run_op("R8 word sign ra eq rt legal", 2'd2, 1, 0, 1, 5'd26, 5'd26, 64'h60, 64'h2, 2'd1,
           64'h0000_0000_FFFF_FFFE, 1, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule